// File: doc/BRIEF.md
# Double-Precision Equality Compare Unit

This unit carries out one equality compare of two 64-bit double-precision operands and reports the outcome as a single bit placed in one 4-bit field of a 32-bit condition register. The caller supplies the instruction word, both operands, the current condition register, the current floating-point status bits and the invalid-input trap enable. The unit checks that the word is the equality-compare instruction. It takes the 3-bit target field index from the word and looks at each operand to find zero, infinity, NaN and denormal values. It then returns a new condition register, new status bits, write enables for both and an interrupt request.

Special operands are not compared the IEEE way. An infinity, a NaN or a denormal sets the invalid-input flag and clears the four guard and sticky bits. When the trap is enabled, the unit raises an interrupt and does not write the condition register. When the trap is off, the raw sign, exponent and fraction are compared as if the value were normal. Positive and negative zero always count as equal.

Operations enter on a valid/ready input stream and leave on a valid/ready result stream. `in_ready` is high whenever the result slot is empty or is being drained in the same cycle. An accepted operation shows its result in the next cycle. While `res_valid` is high and `res_ready` is low, every result output holds still and no new operation is taken. `res_valid` acts as the done pulse. `cr_we`, `stat_we` and `irq` mean something only while it is high.

Top module: `fpd_eq_compare`

## Requirements
- R1: An instruction is recognised only when insn[31:26] = 6'b000100, insn[22:21] = 2'b00 and insn[10:0] = 11'b01011101110. Any other word still yields a result, but with cr_we = 0, stat_we = 0, irq = 0, cr_out = cr_in and stat_out = stat_in.
- R2: For a recognised instruction with valid operands, the result bit is 1 when the two 64-bit patterns are identical and 0 otherwise.
- R3: Two zeros (exponent and fraction all zero) compare equal whatever their signs.
- R4: An operand is invalid when its exponent field (bits 62:52) is all ones, or is zero with a nonzero fraction (bits 51:0). Zero is never invalid. With an invalid operand, stat_we = 1 and stat_out = 5'b10000. In stat_out, bit 4 is the invalid flag, and bits 3 to 0 are high-element guard, high-element sticky, guard and sticky.
- R5: With an invalid operand and trap_en = 1, irq = 1, cr_we = 0 and cr_out = cr_in.
- R6: With an invalid operand and trap_en = 0, the compare goes ahead on the raw bit patterns under the rules of R2 and R3, and cr_we = 1.
- R7: The field index is insn[25:23] = k. The result bit goes to cr_out[30-4k]. Bits 31-4k, 29-4k and 28-4k are 0, and every other bit equals cr_in.
- R8: After reset, res_valid is 0. An operation accepted at a clock edge (in_valid and in_ready) gives res_valid = 1 after that same edge.
- R9: in_ready = 1 when res_valid is 0 or res_ready is 1. While res_valid = 1 and res_ready = 0, res_valid and all result outputs keep their values.
- R10: For a recognised instruction with valid operands, stat_we = 0 and stat_out = stat_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| insn | input | 32 | Instruction word |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| cr_in | input | 32 | Current condition register |
| stat_in | input | 5 | Current status bits {inv, hguard, hsticky, guard, sticky} |
| trap_en | input | 1 | Invalid-input trap enable |
| res_valid | output | 1 | Result present (done) |
| res_ready | input | 1 | Consumer takes the result |
| cr_out | output | 32 | New condition register |
| cr_we | output | 1 | Condition register write enable |
| stat_out | output | 5 | New status bits |
| stat_we | output | 1 | Status write enable |
| irq | output | 1 | Invalid-input interrupt request |

## Verification
A single invalid operand triggers two functions in the same cycle: the status update and, when the trap is enabled, the suppression of the condition-register write. The bench sends NaN, infinity and denormal operands with the trap both on and off. It checks that the flag pattern, the interrupt and the unchanged register all appear together in the one result. The bench also runs a stream with a random consumer stall, so that a finished result is drained in the same cycle a new operation is taken. In that stream, held results must not change and the scoreboard order must match.

// File: rtl/fpdeq_pkg.sv
package fpdeq_pkg;
  localparam int INSN_W    = 32;
  localparam int PRIM_LSB  = 26;
  localparam int PRIM_W    = 6;
  localparam logic [PRIM_W-1:0] PRIM_CODE = 6'b000100;
  localparam int FLD_LSB   = 23;
  localparam int FLD_W     = 3;
  localparam int RSV_LSB   = 21;
  localparam int RSV_W     = 2;
  localparam int XO_W      = 11;
  localparam logic [XO_W-1:0] XO_CODE = 11'b01011101110;
  localparam int REGS_LSB  = XO_W;
  localparam int REGS_W    = RSV_LSB - XO_W;

  typedef struct packed {
    logic inv;
    logic hguard;
    logic hsticky;
    logic guard;
    logic sticky;
  } fstat_t;

  localparam int STAT_W = $bits(fstat_t);
  localparam fstat_t STAT_INVALID = '{inv: 1'b1, default: 1'b0};

  typedef struct packed {
    logic zero;
    logic inf_nan;
    logic denorm;
  } opnd_class_t;
endpackage

// File: rtl/fpdeq_decode.sv
module fpdeq_decode
  import fpdeq_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output logic              match,
  output logic [FLD_W-1:0]  field_idx
);
  logic prim_ok, rsv_ok, xo_ok;
  logic unused_reg_fields;

  assign prim_ok   = insn[PRIM_LSB +: PRIM_W] == PRIM_CODE;
  assign rsv_ok    = insn[RSV_LSB +: RSV_W] == '0;
  assign xo_ok     = insn[0 +: XO_W] == XO_CODE;
  assign match     = prim_ok & rsv_ok & xo_ok;
  assign field_idx = insn[FLD_LSB +: FLD_W];

  // register selectors are read elsewhere; the compare takes operands directly
  assign unused_reg_fields = ^insn[REGS_LSB +: REGS_W];
endmodule

// File: rtl/fpdeq_classify.sv
module fpdeq_classify
  import fpdeq_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W-1:0] mag,
  output opnd_class_t             cls
);
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic exp_ones, exp_zero, frac_zero;

  assign expo      = mag[FRAC_W +: EXP_W];
  assign frac      = mag[0 +: FRAC_W];
  assign exp_ones  = &expo;
  assign exp_zero  = ~|expo;
  assign frac_zero = ~|frac;

  always_comb begin
    cls.zero    = exp_zero & frac_zero;
    cls.inf_nan = exp_ones;
    cls.denorm  = exp_zero & ~frac_zero;
  end
endmodule

// File: rtl/fpdeq_cr_merge.sv
module fpdeq_cr_merge #(
  parameter int CR_W    = 32,
  parameter int FIELD_W = 4,
  parameter int IDX_W   = 3
) (
  input  logic [CR_W-1:0]  cr_in,
  input  logic [IDX_W-1:0] idx,
  input  logic             res_bit,
  output logic [CR_W-1:0]  cr_merged
);
  localparam int NFIELD = CR_W / FIELD_W;

  logic [FIELD_W-1:0] new_field;

  always_comb begin
    new_field = '0;
    new_field[FIELD_W-2] = res_bit;
  end

  // field 0 is the most significant group of bits
  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    localparam int LO = CR_W - FIELD_W * (g + 1);
    assign cr_merged[LO +: FIELD_W] =
      (idx == IDX_W'(g)) ? new_field : cr_in[LO +: FIELD_W];
  end
endmodule

// File: rtl/fpd_eq_compare.sv
module fpd_eq_compare
  import fpdeq_pkg::*;
#(
  parameter int EXP_W   = 11,
  parameter int FRAC_W  = 52,
  parameter int CR_W    = 32,
  parameter int FIELD_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [31:0]               insn,
  input  logic [EXP_W+FRAC_W:0]     opa,
  input  logic [EXP_W+FRAC_W:0]     opb,
  input  logic [CR_W-1:0]           cr_in,
  input  logic [4:0]                stat_in,
  input  logic                      trap_en,
  output logic                      res_valid,
  input  logic                      res_ready,
  output logic [CR_W-1:0]           cr_out,
  output logic                      cr_we,
  output logic [4:0]                stat_out,
  output logic                      stat_we,
  output logic                      irq
);
  localparam int MAG_W = EXP_W + FRAC_W;
  localparam int DW    = MAG_W + 1;

  logic             match;
  logic [FLD_W-1:0] field_idx;
  logic [DW-1:0]    opnd [2];
  opnd_class_t      cls  [2];
  logic             invalid, both_zero, equal, trap;
  logic [CR_W-1:0]  cr_merged;

  logic             nxt_cr_we, nxt_stat_we;
  logic [CR_W-1:0]  nxt_cr;
  fstat_t           nxt_stat;

  logic             vld_q, cr_we_q, stat_we_q, irq_q;
  logic [CR_W-1:0]  cr_q;
  fstat_t           stat_q;
  logic             accept;

  fpdeq_decode u_decode (
    .insn      (insn),
    .match     (match),
    .field_idx (field_idx)
  );

  assign opnd[0] = opa;
  assign opnd[1] = opb;

  for (genvar k = 0; k < 2; k++) begin : g_cls
    fpdeq_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .mag (opnd[k][MAG_W-1:0]),
      .cls (cls[k])
    );
  end

  assign invalid   = cls[0].inf_nan | cls[0].denorm | cls[1].inf_nan | cls[1].denorm;
  assign both_zero = cls[0].zero & cls[1].zero;
  assign equal     = (opa == opb) | both_zero;
  assign trap      = match & invalid & trap_en;

  fpdeq_cr_merge #(.CR_W(CR_W), .FIELD_W(FIELD_W), .IDX_W(FLD_W)) u_merge (
    .cr_in     (cr_in),
    .idx       (field_idx),
    .res_bit   (equal),
    .cr_merged (cr_merged)
  );

  always_comb begin
    nxt_cr_we   = match & ~trap;
    nxt_cr      = nxt_cr_we ? cr_merged : cr_in;
    nxt_stat_we = match & invalid;
    nxt_stat    = nxt_stat_we ? STAT_INVALID : fstat_t'(stat_in);
  end

  assign in_ready = ~vld_q | res_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q     <= 1'b0;
      cr_q      <= '0;
      cr_we_q   <= 1'b0;
      stat_q    <= '0;
      stat_we_q <= 1'b0;
      irq_q     <= 1'b0;
    end else if (accept) begin
      vld_q     <= 1'b1;
      cr_q      <= nxt_cr;
      cr_we_q   <= nxt_cr_we;
      stat_q    <= nxt_stat;
      stat_we_q <= nxt_stat_we;
      irq_q     <= trap;
    end else if (res_ready) begin
      vld_q     <= 1'b0;
    end
  end

  assign res_valid = vld_q;
  assign cr_out    = cr_q;
  assign cr_we     = vld_q & cr_we_q;
  assign stat_out  = stat_q;
  assign stat_we   = vld_q & stat_we_q;
  assign irq       = vld_q & irq_q;
endmodule

// File: rtl/fpdeq_checker.sv
module fpdeq_checker #(
  parameter int CR_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            res_valid,
  input logic            res_ready,
  input logic [CR_W-1:0] cr_out,
  input logic            cr_we,
  input logic [4:0]      stat_out,
  input logic            stat_we,
  input logic            irq
);
  // R5: a trapped compare never writes the condition register
  p_trap_blocks_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && irq |-> !cr_we);

  // R5: an interrupt comes only with the invalid-flag update
  p_irq_has_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat_we && stat_out == 5'b10000);

  // R4: a status write always carries invalid set and guard/sticky cleared
  p_flag_pattern_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |-> stat_out == 5'b10000);

  // R8: an accepted operation is present on the next cycle
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> res_valid);

  // R9: a stalled result holds still
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(cr_out) && $stable(cr_we)
      && $stable(stat_out) && $stable(stat_we) && $stable(irq));
endmodule

bind fpd_eq_compare fpdeq_checker #(.CR_W(CR_W)) u_fpdeq_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .cr_out    (cr_out),
  .cr_we     (cr_we),
  .stat_out  (stat_out),
  .stat_we   (stat_we),
  .irq       (irq)
);

// File: tb/test_fpd_eq_compare.sv
module test_fpd_eq_compare;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] insn = '0;
  logic [63:0] opa = '0, opb = '0;
  logic [31:0] cr_in = '0;
  logic [4:0]  stat_in = '0;
  logic        trap_en = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [31:0] cr_out;
  logic        cr_we;
  logic [4:0]  stat_out;
  logic        stat_we;
  logic        irq;

  always #2 clk = ~clk;

  fpd_eq_compare i_fpd_eq_compare (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .insn(insn), .opa(opa), .opb(opb), .cr_in(cr_in), .stat_in(stat_in),
    .trap_en(trap_en), .res_valid(res_valid), .res_ready(res_ready),
    .cr_out(cr_out), .cr_we(cr_we), .stat_out(stat_out), .stat_we(stat_we),
    .irq(irq)
  );

  typedef struct {
    logic [31:0] cr;
    logic        cr_we;
    logic [4:0]  st;
    logic        st_we;
    logic        irq;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   stall_mode = 1'b0;
  bit   done_all = 1'b0;

  localparam logic [63:0] P_ZERO = 64'h0000_0000_0000_0000;
  localparam logic [63:0] N_ZERO = 64'h8000_0000_0000_0000;
  localparam logic [63:0] P_INF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] QNAN   = 64'h7FF8_0000_0000_0001;
  localparam logic [63:0] QNAN2  = 64'h7FF8_0000_0000_0002;
  localparam logic [63:0] DENORM = 64'h0000_0000_0000_0123;
  localparam logic [63:0] ONE    = 64'h3FF0_0000_0000_0000;

  function automatic logic [31:0] mk_insn(input int k);
    return {6'b000100, 3'(k), 2'b00, 5'd3, 5'd7, 11'b01011101110};
  endfunction

  function automatic bit is_bad(input logic [63:0] v);
    return (v[62:52] == 11'h7FF) || (v[62:52] == 0 && v[51:0] != 0);
  endfunction

  function automatic exp_t model(input logic [31:0] w, input logic [63:0] a,
      input logic [63:0] b, input logic [31:0] cr, input logic [4:0] st,
      input logic trap, input string tag);
    exp_t e;
    bit ok, bad, eq;
    int k;
    ok  = (w[31:26] == 6'b000100) && (w[22:21] == 2'b00) && (w[10:0] == 11'h2EE);
    bad = is_bad(a) || is_bad(b);
    eq  = (a == b) || (a[62:0] == 0 && b[62:0] == 0);
    k   = int'(w[25:23]);
    e.tag = tag; e.cr = cr; e.cr_we = 0; e.st = st; e.st_we = 0; e.irq = 0;
    if (ok) begin
      if (bad) begin e.st = 5'b10000; e.st_we = 1; end
      if (bad && trap) e.irq = 1;
      else begin
        e.cr_we = 1;
        e.cr[31-4*k] = 1'b0;
        e.cr[30-4*k] = eq;
        e.cr[29-4*k] = 1'b0;
        e.cr[28-4*k] = 1'b0;
      end
    end
    return e;
  endfunction

  task automatic check(input string tag, input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: called at a falling edge
  task automatic send(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                      input logic [31:0] cr, input logic [4:0] st, input logic trap,
                      input string tag);
    in_valid = 1'b1; insn = w; opa = a; opb = b; cr_in = cr; stat_in = st; trap_en = trap;
    while (!in_ready) @(negedge clk);
    q.push_back(model(w, a, b, cr, st, trap, tag));
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", res_valid === 1'b1, "res_valid after accept", 64'(res_valid), 64'd1);
  endtask

  always @(posedge clk) #1 res_ready <= stall_mode ? 1'($urandom % 2) : 1'b1;

  // monitor and scoreboard
  bit          held = 1'b0;
  logic [31:0] h_cr;
  logic [4:0]  h_st;
  logic [2:0]  h_fl;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held)
        check("R9", res_valid && cr_out == h_cr && stat_out == h_st
              && {cr_we, stat_we, irq} == h_fl, "stalled result changed",
              {cr_out, 24'(stat_out), 5'(res_valid), cr_we, stat_we, irq},
              {h_cr, 24'(h_st), 5'd1, h_fl});
      held = res_valid && !res_ready;
      h_cr = cr_out; h_st = stat_out; h_fl = {cr_we, stat_we, irq};
      if (res_valid && res_ready) begin
        if (q.size() == 0)
          check("R8", 1'b0, "result with empty scoreboard", 64'd1, 64'd0);
        else begin
          exp_t e;
          e = q.pop_front();
          check(e.tag, cr_out == e.cr, "cr_out", 64'(cr_out), 64'(e.cr));
          check(e.tag, cr_we == e.cr_we, "cr_we", 64'(cr_we), 64'(e.cr_we));
          check(e.tag, stat_out == e.st, "stat_out", 64'(stat_out), 64'(e.st));
          check(e.tag, stat_we == e.st_we, "stat_we", 64'(stat_we), 64'(e.st_we));
          check(e.tag, irq == e.irq, "irq", 64'(irq), 64'(e.irq));
        end
      end
    end
  end

  task automatic finish_run();
    if (!done_all) begin
      done_all = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    finish_run();
  end

  function automatic logic [63:0] pick(input int c);
    case (c)
      0: return ONE;
      1: return {$urandom, $urandom};
      2: return ($urandom % 2) ? P_ZERO : N_ZERO;
      3: return P_INF;
      4: return QNAN;
      default: return DENORM;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R8", res_valid === 1'b0, "res_valid in reset", 64'(res_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", in_ready === 1'b1, "in_ready when empty", 64'(in_ready), 64'd1);

    // R2: plain compares
    send(mk_insn(0), ONE, ONE, 32'h1234_5678, 5'b01111, 0, "R2");
    send(mk_insn(0), ONE, ONE ^ 64'd1, 32'h1234_5678, 5'b00101, 0, "R2");
    send(mk_insn(2), ONE, ONE | N_ZERO, 32'hFFFF_FFFF, 5'b00000, 0, "R2");
    // R3: signed zeros
    send(mk_insn(1), P_ZERO, N_ZERO, 32'h0, 5'b00011, 1, "R3");
    send(mk_insn(5), N_ZERO, N_ZERO, 32'hAAAA_5555, 5'b00000, 0, "R3");
    // R10: valid operands leave status alone
    send(mk_insn(4), ONE, P_ZERO, 32'h0F0F_0F0F, 5'b11010, 1, "R10");
    // R4/R6: untrapped invalid operands compared raw
    send(mk_insn(3), P_INF, P_INF, 32'h0, 5'b01111, 0, "R6");
    send(mk_insn(3), QNAN, QNAN2, 32'hFFFF_FFFF, 5'b01111, 0, "R6");
    send(mk_insn(6), DENORM, DENORM, 32'h0, 5'b00110, 0, "R4");
    send(mk_insn(6), ONE, DENORM, 32'h0, 5'b00110, 0, "R4");
    // R5: trapped invalid
    send(mk_insn(7), QNAN, ONE, 32'hDEAD_BEEF, 5'b01111, 1, "R5");
    send(mk_insn(0), P_ZERO, P_INF, 32'h1357_9BDF, 5'b00001, 1, "R5");
    // R1: non-matching words
    send(mk_insn(2) ^ 32'h8000_0000, QNAN, ONE, 32'hCAFE_F00D, 5'b01010, 1, "R1");
    send(mk_insn(2) | 32'h0020_0000, QNAN, ONE, 32'hCAFE_F00D, 5'b01010, 1, "R1");
    send(mk_insn(2) ^ 32'h0000_0001, ONE, ONE, 32'hCAFE_F00D, 5'b01010, 0, "R1");
    // R7: every field position, both result values
    for (int k = 0; k < 8; k++) begin
      send(mk_insn(k), ONE, ONE, 32'hFFFF_FFFF, 5'b0, 0, "R7");
      send(mk_insn(k), ONE, P_ZERO, 32'h0000_0000, 5'b0, 0, "R7");
    end

    // R9: stream under random consumer stalls
    stall_mode = 1'b1;
    for (int n = 0; n < 60; n++) begin
      logic [63:0] a, b;
      logic [31:0] w;
      a = pick(int'($urandom % 6));
      b = ($urandom % 3 == 0) ? a : pick(int'($urandom % 6));
      w = mk_insn(int'($urandom % 8));
      if ($urandom % 8 == 0) w = w ^ 32'h0000_0400;
      send(w, a, b, {$urandom}, 5'($urandom), 1'($urandom % 2), "R9");
      if ($urandom % 4 == 0) @(negedge clk);
    end
    stall_mode = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule